// File: doc/BRIEF.md
# Gated Frequency Counter with Offset

This block measures the frequency of a digitized oscillator signal. It counts the rising edges of that signal during a gate window of fixed length, timed by the reference clock. With a 100 ms window, one count stands for 10 Hz. It then applies an intermediate-frequency offset to the count, adding or subtracting it, and so turns the oscillator count into a signal-frequency value in binary.

The count chain has two parts:
- A low-order prescaler. Its value cannot be read.
- A high-order register. Its value can be read directly.

When the gate closes, the block injects probe pulses into the prescaler until the prescaler overflows. The number of probes needed gives back the hidden residual. Two inputs choose the offset: a sideband select picks one of two stored offsets, and an add/subtract select picks the direction.

Each measure cycle has three steps: gate, probe, and finish. In the finish step the block updates the outputs and clears the chain, and the next gate then opens. The valid strobe marks every second measurement, so that a display driven from it refreshes at half the measure rate.

Top module: `gated_freq_offset`

## Requirements
- R1: While reset is held and in the cycle after it is released, `raw_count`, `result` and `result_valid` are all 0.
- R2: `raw_count` equals the number of rising edges of `sig_in` that occur while the gate is open. The gate opens for `GATE_CYCLES` reference cycles directly after reset and again after each measure cycle.
- R3: The low `PRE_W` bits of `raw_count` are correct for every residual, including a residual of 0 and a residual of 2^PRE_W-1. The residual is recovered as 2^PRE_W minus the number of probe pulses that make the prescaler overflow, taken modulo 2^PRE_W.
- R4: When `add_sel` is 1 at the end of a measurement, `result` equals `raw_count` plus the selected offset.
- R5: When `add_sel` is 0, `result` equals `raw_count` minus the selected offset. If the difference would be negative, `result` is 0 instead.
- R6: When `usb_sel` is 1 the offset is `USB_OFS`, and when it is 0 the offset is `LSB_OFS`.
- R7: All count stages are cleared at the end of each measurement. A following gate with no input edges therefore gives `raw_count` = 0.
- R8: `result_valid` is a one-cycle pulse. It is raised on the 2nd, 4th, 6th, … completed measurement after reset, and never on an odd-numbered one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that times the gate |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Digitized oscillator signal, asynchronous to the reference clock |
| add_sel | input | 1 | 1 adds the offset, 0 subtracts it |
| usb_sel | input | 1 | 1 selects the upper-sideband offset, 0 the lower-sideband offset |
| raw_count | output | HI_W+PRE_W | Edge count of the last completed gate |
| result | output | HI_W+PRE_W+1 | Offset-corrected count of the last completed gate |
| result_valid | output | 1 | One-cycle strobe on every second completed measurement |

## Verification
An error in the probe readout shows up only in the low `PRE_W` bits of `raw_count`. It is visible about 2^PRE_W cycles after the gate closes, so the bench uses edge counts whose residuals are 0 and 2^PRE_W-1. A chain that is not cleared shows up one full measure cycle later, as a nonzero count from an idle gate. A strobe whose parity has drifted shows up as a pulse after the very first measurement. Offset faults show up in `result` at the same time as the count: an offset in the wrong direction, a mixed-up sideband choice, or a missing floor at zero.

// File: rtl/gfo_pkg.sv
package gfo_pkg;

  typedef enum logic [1:0] {
    ST_GATE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_DONE  = 2'd2
  } gfo_state_t;

  // Rebuild the full count: high register times the modulus, plus the
  // residual recovered from the number of probe pulses.
  function automatic logic [31:0] full_count(input logic [31:0] hi,
                                             input logic [31:0] probes,
                                             input int unsigned pre_w);
    logic [31:0] modulus;
    logic [31:0] residual;
    modulus  = 32'd1 << pre_w;
    residual = (modulus - probes) & (modulus - 32'd1);
    return (hi << pre_w) + residual;
  endfunction

  // Add the offset, or subtract it with a floor at zero.
  function automatic logic [32:0] apply_offset(input logic [31:0] cnt,
                                               input logic [31:0] ofs,
                                               input logic add);
    if (add)
      return {1'b0, cnt} + {1'b0, ofs};
    else if (cnt >= ofs)
      return {1'b0, cnt - ofs};
    else
      return 33'd0;
  endfunction

endpackage

// File: rtl/gfo_edge_sync.sv
module gfo_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic sig_async,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sig_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  // R2: two rising edges cannot be reported in back-to-back cycles
  p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/gfo_chain.sv
module gfo_chain #(
  parameter int PRE_W = 4,
  parameter int HI_W  = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            inc,
  input  logic            carry_en,
  output logic            wrap,
  output logic [HI_W-1:0] hi
);
  logic [PRE_W-1:0] pre_q;   // hidden stage, never leaves this module
  logic [HI_W-1:0]  hi_q;

  assign wrap = inc && (pre_q == {PRE_W{1'b1}});
  assign hi   = hi_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      hi_q  <= '0;
    end else begin
      if (inc)
        pre_q <= pre_q + 1'b1;
      if (wrap && carry_en)
        hi_q <= hi_q + 1'b1;
    end
  end

  // R7: a clear leaves an empty chain
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hi_q == '0 && pre_q == '0));
  // R3: while probing (no carry), the readable register does not move
  p_probe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!carry_en && !clr) |=> $stable(hi_q));
endmodule

// File: rtl/gated_freq_offset.sv
module gated_freq_offset
  import gfo_pkg::*;
#(
  parameter int GATE_CYCLES = 2000,
  parameter int PRE_W       = 4,
  parameter int HI_W        = 12,
  parameter int USB_OFS     = 250,
  parameter int LSB_OFS     = 120
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sig_in,
  input  logic                 add_sel,
  input  logic                 usb_sel,
  output logic [HI_W+PRE_W-1:0] raw_count,
  output logic [HI_W+PRE_W:0]   result,
  output logic                 result_valid
);
  localparam int CNT_W  = HI_W + PRE_W;
  localparam int RES_W  = CNT_W + 1;
  localparam int MOD    = 1 << PRE_W;
  localparam int GCNT_W = $clog2(GATE_CYCLES + 1);
  localparam int PRB_W  = PRE_W + 1;

  gfo_state_t       st_q;
  logic [GCNT_W-1:0] gate_cnt;
  logic [PRB_W-1:0]  probe_cnt;
  logic [PRB_W-1:0]  probes_q;
  logic              par_q;
  logic [CNT_W-1:0]  raw_q;
  logic [RES_W-1:0]  res_q;
  logic              valid_q;

  // named internal events
  logic              edge_evt;
  logic              gate_last;
  logic              probe_evt;
  logic              done_evt;
  logic              wrap;
  logic [HI_W-1:0]   hi;
  logic              chain_inc;
  logic              carry_en;
  logic [31:0]       cnt_full;
  logic [32:0]       res_full;
  logic [31:0]       ofs_sel;

  gfo_edge_sync i_sync (
    .clk       (clk),
    .rst       (rst),
    .sig_async (sig_in),
    .rise      (edge_evt)
  );

  assign gate_last = (st_q == ST_GATE) && (gate_cnt == GCNT_W'(GATE_CYCLES - 1));
  assign probe_evt = (st_q == ST_PROBE);
  assign done_evt  = (st_q == ST_DONE);
  assign chain_inc = probe_evt || ((st_q == ST_GATE) && edge_evt);
  assign carry_en  = (st_q == ST_GATE);

  gfo_chain #(.PRE_W(PRE_W), .HI_W(HI_W)) i_chain (
    .clk      (clk),
    .rst      (rst),
    .clr      (done_evt),
    .inc      (chain_inc),
    .carry_en (carry_en),
    .wrap     (wrap),
    .hi       (hi)
  );

  assign ofs_sel  = usb_sel ? 32'(USB_OFS) : 32'(LSB_OFS);
  assign cnt_full = full_count(32'(hi), 32'(probes_q), PRE_W);
  assign res_full = apply_offset(32'(cnt_full[CNT_W-1:0]), ofs_sel, add_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_GATE;
      gate_cnt  <= '0;
      probe_cnt <= '0;
      probes_q  <= '0;
      par_q     <= 1'b0;
      raw_q     <= '0;
      res_q     <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        ST_GATE: begin
          if (gate_last) begin
            gate_cnt <= '0;
            st_q     <= ST_PROBE;
          end else begin
            gate_cnt <= gate_cnt + 1'b1;
          end
        end
        ST_PROBE: begin
          probe_cnt <= probe_cnt + 1'b1;
          if (wrap) begin
            probes_q <= probe_cnt + 1'b1;
            st_q     <= ST_DONE;
          end
        end
        ST_DONE: begin
          raw_q     <= cnt_full[CNT_W-1:0];
          res_q     <= res_full[RES_W-1:0];
          valid_q   <= par_q;
          par_q     <= ~par_q;
          probe_cnt <= '0;
          st_q      <= ST_GATE;
        end
        default: st_q <= ST_GATE;
      endcase
    end
  end

  assign raw_count    = raw_q;
  assign result       = res_q;
  assign result_valid = valid_q;

  // R3: overflow is reached within one modulus of probes
  p_probe_bound_r3: assert property (@(posedge clk) disable iff (rst)
    probe_evt |-> (probe_cnt < PRB_W'(MOD)));
  // R8: the strobe is one cycle wide
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // R8: strobe only follows a measurement end
  p_strobe_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(done_evt));
  // R5: subtraction never raises the value
  p_sub_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (done_evt && !add_sel) |=> (result <= {1'b0, raw_count}));
  // R4: addition never lowers the value
  p_add_grow_r4: assert property (@(posedge clk) disable iff (rst)
    (done_evt && add_sel) |=> (result >= {1'b0, raw_count}));
  // R2: the gate is left only after its last cycle
  p_gate_len_r2: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_GATE) && !gate_last) |=> (st_q == ST_GATE));
endmodule

// File: tb/test_gated_freq_offset.sv
module test_gated_freq_offset;
  localparam int CLK_PERIOD = 10;
  localparam int GATE = 2000;
  localparam int PW   = 4;
  localparam int HW   = 12;
  localparam int UOFS = 250;
  localparam int LOFS = 120;
  localparam int MODV = 1 << PW;
  localparam int MEAS = GATE + MODV + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic add_sel = 1'b0;
  logic usb_sel = 1'b0;
  logic [HW+PW-1:0] raw_count;
  logic [HW+PW:0]   result;
  logic result_valid;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  int elapsed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_freq_offset #(.GATE_CYCLES(GATE), .PRE_W(PW), .HI_W(HW),
                      .USB_OFS(UOFS), .LSB_OFS(LOFS)) i_gated_freq_offset (
    .clk(clk), .rst(rst), .sig_in(sig_in), .add_sel(add_sel),
    .usb_sel(usb_sel), .raw_count(raw_count), .result(result),
    .result_valid(result_valid)
  );

  always @(negedge clk) if (!rst && result_valid) strobes++;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    elapsed += n;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    strobes = 0;
    elapsed = 0;
  endtask

  function automatic longint expect_res(input int n, input bit add, input bit usb);
    int o;
    o = usb ? UOFS : LOFS;
    if (add) return n + o;
    return (n > o) ? n - o : 0;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", raw_count, 0);
    chk("R1 result in reset", result, 0);
    chk("R1 valid in reset", result_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 raw after release", raw_count, 0);
  endtask

  // n pulses inside the first gate, none in the second
  task automatic t_measure(input string tag, input int n, input bit add, input bit usb);
    add_sel = add;
    usb_sel = usb;
    do_reset();
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1; step(2);
      sig_in = 1'b0; step(2);
    end
    step(MEAS + 10 - elapsed);
    chk({tag, " R2 raw count"}, raw_count, n);
    chk({tag, " R3 low bits"}, raw_count % MODV, n % MODV);
    chk({tag, " R4/R5/R6 result"}, result, expect_res(n, add, usb));
    chk({tag, " R8 no strobe on first"}, strobes, 0);
    step(2 * MEAS + 10 - elapsed);
    chk({tag, " R7 cleared chain"}, raw_count, 0);
    chk({tag, " R8 strobe on second"}, strobes, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_measure("zero", 0, 1'b1, 1'b1);
    t_measure("res0", 16, 1'b1, 1'b0);
    t_measure("res15", 15, 1'b1, 1'b1);
    t_measure("mixed", 37, 1'b0, 1'b0);
    t_measure("sub_exact", 250, 1'b0, 1'b1);
    t_measure("sub_sat", 100, 1'b0, 1'b1);
    t_measure("add_lsb", 300, 1'b1, 1'b0);
    t_measure("sub_lsb", 300, 1'b0, 1'b0);
    t_measure("big", 479, 1'b1, 1'b1);
    // R8: over four measurements exactly two strobes
    do_reset();
    step(4 * MEAS + 10);
    chk("R8 two strobes in four", strobes, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule